// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block is the control layer between a processor-side register bus and an on-chip flash array. Software writes control bits to select one of four array operations: program, erase, program-verify and erase-verify. The block checks the order of those writes. A setup bit must be set and have settled before its matching action bit is honoured. At most one action may run at a time. Program and erase also need a board-level write-enable input to be high.

Before a program pulse, the block collects one page of 32 bytes through a byte-write port and holds both the page base address and the data. The page must start on a 32-byte boundary and must arrive at consecutive addresses. Two microsecond timers set the minimum settling times. Both count a prescaled clock tick against values supplied at the ports:
- one timer starts when the software enable is set;
- the other starts when a setup bit is set.

While a program or erase operation runs, array reads are answered with a stall instead of a grant. The block counts program attempts and refuses new ones once a configured maximum is reached. Each rule that is broken sets a sticky error bit. Clearing the software enable returns the whole block to its idle state.

Top module: `flash_seq_ctrl`

## Requirements
- R1: `mode_o` encodes idle=0, program=1, erase=2, program-verify=3, erase-verify=4. In the control register (`reg_sel`=0), bit0 is the software enable, bit1 program, bit2 erase, bit3 program-verify and bit4 erase-verify. In the setup register (`reg_sel`=1), bit0 is program-setup and bit1 is erase-setup. Entering program or erase gives a one-cycle pulse on `arr_start`.
- R2: An action bit written without its setup bit leaves the mode idle and sets sequence error `err_o[0]`. Verify modes require both setup bits to be clear.
- R3: While `fwe_i`=0, a write that sets the program bit, the erase bit or a setup bit has no effect: the mode, the setup bits and the errors stay unchanged.
- R4: While the mode is program or erase, `rd_req` gives `rd_stall`=1 and `rd_ok`=0. In every other mode, `rd_req` gives `rd_ok`=1.
- R5: Program is entered only when exactly 32 bytes have been latched. Otherwise the page is discarded, the mode stays idle and page error `err_o[2]` is set. Leaving program also discards the page.
- R6: The first byte of a page must have an address whose low 5 bits are zero. Each later byte must sit at the base address plus its index. A violation, or a 33rd byte, discards the page and sets `err_o[2]`.
- R7: A byte written before `swe_wait_us` microseconds have passed since the software enable rose is not latched and sets wait error `err_o[1]`.
- R8: An action bit written before `setup_wait_us` microseconds have passed since its setup bit rose leaves the mode idle and sets `err_o[1]`.
- R9: Each entry into program increments `tries_o`. Once `tries_o` equals MAX_TRIES, a program request is refused and sets limit error `err_o[4]`.
- R10: A byte latched while `bw_blank`=0 (target byte not erased) sets `err_o[3]`.
- R11: Writing more than one action bit, or requesting a different action while one is active, returns the mode to idle and sets `err_o[0]`. Setting both setup bits together is refused with `err_o[0]`.
- R12: Writing the control register with bit0=0 clears the mode, the setup bits, the errors, `tries_o` and the page.
- R13: After reset the mode is idle, `err_o`, `tries_o` and `arr_start` are zero, and reads are granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwe_i | input | 1 | Board-level write enable for program and erase |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = setup register |
| reg_wdata | input | 8 | Register write data |
| swe_wait_us | input | WAIT_W | Settling time after the software enable, in microseconds |
| setup_wait_us | input | WAIT_W | Settling time after a setup bit, in microseconds |
| bw_valid | input | 1 | Page byte write strobe |
| bw_addr | input | ADDR_W | Page byte address |
| bw_data | input | 8 | Page byte data |
| bw_blank | input | 1 | Array reports the addressed byte as erased |
| rd_req | input | 1 | Array read request |
| rd_ok | output | 1 | Read granted |
| rd_stall | output | 1 | Read refused: operation in progress |
| mode_o | output | 3 | Current array mode |
| err_o | output | 5 | Sticky error flags |
| tries_o | output | $clog2(MAX_TRIES+1) | Program attempts since the software enable |
| arr_start | output | 1 | One-cycle start pulse to the array |
| pg_base_o | output | ADDR_W | Latched page base address |
| pg_data_o | output | PAGE_BYTES*8 | Latched page data, byte i at bits 8i+7:8i |

## Verification
Several rules are checked on every cycle by assertions. Every start of a program or erase must follow a high write-enable input and an expired setup timer. Program may only be entered from a full page. The attempt count never passes its limit. A latched page base is always aligned. A timer restart always clears its done flag. Clearing the software enable always empties the errors and the attempt count.

Other behaviour is only visible through the bench's scenarios. These include the rejection of each illegal write pattern, the page discard after a bad address, and a page latched before a late setup bit still being usable. They also include the read stall during program and the refusal after the attempt limit.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    MD_IDLE  = 3'd0,
    MD_PROG  = 3'd1,
    MD_ERASE = 3'd2,
    MD_PVFY  = 3'd3,
    MD_EVFY  = 3'd4
  } fmode_e;

  localparam int unsigned ERR_W     = 5;
  localparam int unsigned ERR_SEQ   = 0;
  localparam int unsigned ERR_WAIT  = 1;
  localparam int unsigned ERR_PAGE  = 2;
  localparam int unsigned ERR_BLANK = 3;
  localparam int unsigned ERR_LIMIT = 4;

  // control register bit positions (software decodes these)
  localparam int unsigned CB_SWE = 0;
  localparam int unsigned SB_PSU = 0;
  localparam int unsigned SB_ESU = 1;

  // address sits on a page boundary (page size is a power of two)
  function automatic logic on_page_start(input logic [31:0] a, input int unsigned pb);
    logic [31:0] m;
    m = pb - 1;
    return (a & m) == 32'd0;
  endfunction

  // address the next byte of a page must carry
  function automatic logic [31:0] next_addr(input logic [31:0] base, input logic [31:0] idx);
    return base + idx;
  endfunction

  // one-hot action field -> mode (caller guarantees at most one bit)
  function automatic fmode_e acts_to_mode(input logic [3:0] a);
    fmode_e m;
    m = MD_IDLE;
    if (a[0]) m = MD_PROG;
    else if (a[1]) m = MD_ERASE;
    else if (a[2]) m = MD_PVFY;
    else if (a[3]) m = MD_EVFY;
    return m;
  endfunction

endpackage

// File: rtl/flash_us_tick.sv
module flash_us_tick #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/flash_us_wait.sv
module flash_us_wait #(
  parameter int unsigned WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              restart,
  input  logic [WAIT_W-1:0] target,
  output logic              done
);
  // one extra bit so a partial first tick never shortens the wait
  logic [WAIT_W:0] elapsed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     elapsed <= '0;
    else if (restart)               elapsed <= '0;
    else if (tick && elapsed != '1) elapsed <= elapsed + 1'b1;
  end

  assign done = elapsed > {1'b0, target};

  // R8
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !done);
endmodule

// File: rtl/flash_page_latch.sv
module flash_page_latch
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned PAGE_BYTES = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [7:0]              wr_data,
  input  logic                    clear,
  output logic                    full,
  output logic                    fault,
  output logic [ADDR_W-1:0]       base,
  output logic [PAGE_BYTES*8-1:0] data
);
  localparam int unsigned CNT_W = $clog2(PAGE_BYTES + 1);

  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] base_q;
  logic              first, accept, bad_addr;

  assign first = (cnt == '0);
  assign full  = (cnt == CNT_W'(PAGE_BYTES));

  always_comb begin
    if (first) bad_addr = !on_page_start(32'(wr_addr), PAGE_BYTES);
    else       bad_addr = 32'(wr_addr) != next_addr(32'(base_q), 32'(cnt));
  end

  assign fault  = wr_en && !clear && (full || bad_addr);
  assign accept = wr_en && !clear && !fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      base_q <= '0;
    end else if (clear || fault) begin
      cnt <= '0;
    end else if (accept) begin
      if (first) base_q <= wr_addr;
      cnt <= cnt + 1'b1;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              byte_q <= '0;
      else if (accept && cnt == CNT_W'(g)) byte_q <= wr_data;
    end
    assign data[g*8 +: 8] = byte_q;
  end

  assign base = base_q;

  // R6
  base_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> on_page_start(32'(base_q), PAGE_BYTES));
  // R5
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(PAGE_BYTES));
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned PAGE_BYTES = 32,
  parameter int unsigned TICK_DIV   = 8,
  parameter int unsigned WAIT_W     = 8,
  parameter int unsigned MAX_TRIES  = 16,
  localparam int unsigned TRY_W     = $clog2(MAX_TRIES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fwe_i,
  input  logic                    reg_wr,
  input  logic                    reg_sel,
  input  logic [7:0]              reg_wdata,
  input  logic [WAIT_W-1:0]       swe_wait_us,
  input  logic [WAIT_W-1:0]       setup_wait_us,
  input  logic                    bw_valid,
  input  logic [ADDR_W-1:0]       bw_addr,
  input  logic [7:0]              bw_data,
  input  logic                    bw_blank,
  input  logic                    rd_req,
  output logic                    rd_ok,
  output logic                    rd_stall,
  output logic [2:0]              mode_o,
  output logic [ERR_W-1:0]        err_o,
  output logic [TRY_W-1:0]        tries_o,
  output logic                    arr_start,
  output logic [ADDR_W-1:0]       pg_base_o,
  output logic [PAGE_BYTES*8-1:0] pg_data_o
);
  localparam int unsigned N_TMR   = 2;
  localparam int unsigned TMR_SWE = 0;
  localparam int unsigned TMR_SU  = 1;
  localparam logic [TRY_W-1:0] TRY_MAX = TRY_W'(MAX_TRIES);

  // ---------------- state ----------------
  fmode_e           mode_q, mode_n;
  logic             swe_q, swe_n, psu_q, psu_n, esu_q, esu_n;
  logic [ERR_W-1:0] err_q, err_set, data_evt;
  logic [TRY_W-1:0] tries_q;
  logic             arr_start_q;

  // ---------------- named events ----------------
  logic       a_wr, b_wr, clr_all, try_inc, page_clr, pg_wr;
  logic       enter_pe, busy;
  logic       us_tick, pg_full, pg_fault;
  logic [3:0] acts;
  fmode_e     acts_mode;
  logic [N_TMR-1:0]  tmr_restart, tmr_done;
  logic [WAIT_W-1:0] tmr_target [N_TMR];

  assign a_wr      = reg_wr && !reg_sel;
  assign b_wr      = reg_wr && reg_sel;
  assign acts      = reg_wdata[4:1];
  assign acts_mode = acts_to_mode(acts);
  assign busy      = (mode_q == MD_PROG) || (mode_q == MD_ERASE);

  // ---------------- timing ----------------
  flash_us_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(us_tick));

  assign tmr_target[TMR_SWE] = swe_wait_us;
  assign tmr_target[TMR_SU]  = setup_wait_us;

  for (genvar t = 0; t < N_TMR; t++) begin : g_wait
    flash_us_wait #(.WAIT_W(WAIT_W)) u_wait (
      .clk(clk), .rst_n(rst_n), .tick(us_tick),
      .restart(tmr_restart[t]), .target(tmr_target[t]), .done(tmr_done[t]));
  end

  // ---------------- page latch ----------------
  flash_page_latch #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_page (
    .clk(clk), .rst_n(rst_n), .wr_en(pg_wr), .wr_addr(bw_addr), .wr_data(bw_data),
    .clear(page_clr || clr_all), .full(pg_full), .fault(pg_fault),
    .base(pg_base_o), .data(pg_data_o));

  // ---------------- sequencing rules ----------------
  always_comb begin
    mode_n      = mode_q;
    swe_n       = swe_q;
    psu_n       = psu_q;
    esu_n       = esu_q;
    err_set     = '0;
    clr_all     = 1'b0;
    try_inc     = 1'b0;
    page_clr    = 1'b0;
    pg_wr       = 1'b0;
    tmr_restart = '0;

    if (a_wr) begin
      if (!reg_wdata[CB_SWE]) begin
        clr_all = 1'b1;
        mode_n  = MD_IDLE;
      end else begin
        swe_n = 1'b1;
        tmr_restart[TMR_SWE] = !swe_q;
        if (acts == 4'd0) begin
          mode_n = MD_IDLE;
        end else if ($countones(acts) > 1 || !swe_q) begin
          err_set[ERR_SEQ] = 1'b1;
          mode_n = MD_IDLE;
        end else if (mode_q != MD_IDLE && acts_mode != mode_q) begin
          err_set[ERR_SEQ] = 1'b1;
          mode_n = MD_IDLE;
        end else if (mode_q == MD_IDLE) begin
          unique case (acts_mode)
            MD_PROG: if (fwe_i) begin
              if (!psu_q)                  err_set[ERR_SEQ]   = 1'b1;
              else if (!tmr_done[TMR_SU])  err_set[ERR_WAIT]  = 1'b1;
              else if (tries_q == TRY_MAX) err_set[ERR_LIMIT] = 1'b1;
              else if (!pg_full) begin
                err_set[ERR_PAGE] = 1'b1;
                page_clr = 1'b1;
              end else begin
                mode_n  = MD_PROG;
                try_inc = 1'b1;
              end
            end
            MD_ERASE: if (fwe_i) begin
              if (!esu_q)                 err_set[ERR_SEQ]  = 1'b1;
              else if (!tmr_done[TMR_SU]) err_set[ERR_WAIT] = 1'b1;
              else                        mode_n = MD_ERASE;
            end
            MD_PVFY, MD_EVFY: begin
              if (psu_q || esu_q) err_set[ERR_SEQ] = 1'b1;
              else                mode_n = acts_mode;
            end
            default: ;
          endcase
        end
      end
    end

    if (b_wr) begin
      if (reg_wdata[SB_PSU] && reg_wdata[SB_ESU]) begin
        err_set[ERR_SEQ] = 1'b1;
      end else if ((reg_wdata[SB_PSU] || reg_wdata[SB_ESU]) && !fwe_i) begin
        // gated off by the board-level enable: ignored
      end else if (!swe_q || mode_q != MD_IDLE) begin
        err_set[ERR_SEQ] = 1'b1;
      end else begin
        psu_n = reg_wdata[SB_PSU];
        esu_n = reg_wdata[SB_ESU];
        tmr_restart[TMR_SU] = (reg_wdata[SB_PSU] && !psu_q) ||
                              (reg_wdata[SB_ESU] && !esu_q);
      end
    end

    if (bw_valid && swe_q && !clr_all) begin
      if (!tmr_done[TMR_SWE])    err_set[ERR_WAIT] = 1'b1;
      else if (mode_q != MD_IDLE) err_set[ERR_SEQ] = 1'b1;
      else                       pg_wr = 1'b1;
    end

    if (mode_q == MD_PROG && mode_n != MD_PROG) page_clr = 1'b1;
  end

  always_comb begin
    data_evt = '0;
    data_evt[ERR_PAGE]  = pg_fault;
    data_evt[ERR_BLANK] = pg_wr && !pg_fault && !page_clr && !bw_blank;
  end

  assign enter_pe = (mode_n == MD_PROG || mode_n == MD_ERASE) && (mode_n != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MD_IDLE;
      swe_q       <= 1'b0;
      psu_q       <= 1'b0;
      esu_q       <= 1'b0;
      err_q       <= '0;
      tries_q     <= '0;
      arr_start_q <= 1'b0;
    end else if (clr_all) begin
      mode_q      <= MD_IDLE;
      swe_q       <= 1'b0;
      psu_q       <= 1'b0;
      esu_q       <= 1'b0;
      err_q       <= '0;
      tries_q     <= '0;
      arr_start_q <= 1'b0;
    end else begin
      mode_q      <= mode_n;
      swe_q       <= swe_n;
      psu_q       <= psu_n;
      esu_q       <= esu_n;
      err_q       <= err_q | err_set | data_evt;
      tries_q     <= tries_q + TRY_W'(try_inc);
      arr_start_q <= enter_pe;
    end
  end

  assign mode_o    = mode_q;
  assign err_o     = err_q;
  assign tries_o   = tries_q;
  assign arr_start = arr_start_q;
  assign rd_ok     = rd_req && !busy;
  assign rd_stall  = rd_req && busy;

  // ---------------- checks ----------------
  // R3
  start_needs_fwe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |-> $past(fwe_i));
  // R8
  start_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |-> $past(tmr_done[TMR_SU]));
  // R5
  prog_from_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_PROG && $past(mode_q) != MD_PROG) |-> $past(pg_full));
  // R9
  tries_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q <= TRY_MAX);
  // R12
  swe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (err_q == '0 && tries_q == '0 && mode_q == MD_IDLE));
endmodule

// File: tb/flash_seq_ctrl_test.sv
`timescale 1ns/1ps
module flash_seq_ctrl_test;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned PB     = 32;
  localparam int unsigned WW     = 8;
  localparam int unsigned MAXT   = 2;
  localparam int unsigned TW     = $clog2(MAXT + 1);

  logic clk = 1'b0, rst_n = 1'b0, fwe_i = 1'b1;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [WW-1:0] swe_wait_us = 8'd3, setup_wait_us = 8'd2;
  logic bw_valid = 1'b0, bw_blank = 1'b1, rd_req = 1'b0;
  logic [ADDR_W-1:0] bw_addr = '0;
  logic [7:0] bw_data = '0;
  logic rd_ok, rd_stall, arr_start;
  logic [2:0] mode_o;
  logic [4:0] err_o;
  logic [TW-1:0] tries_o;
  logic [ADDR_W-1:0] pg_base_o;
  logic [PB*8-1:0] pg_data_o;

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flash_seq_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PB), .TICK_DIV(4), .WAIT_W(WW),
                   .MAX_TRIES(MAXT)) uut (
    .clk(clk), .rst_n(rst_n), .fwe_i(fwe_i), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .swe_wait_us(swe_wait_us), .setup_wait_us(setup_wait_us),
    .bw_valid(bw_valid), .bw_addr(bw_addr), .bw_data(bw_data), .bw_blank(bw_blank),
    .rd_req(rd_req), .rd_ok(rd_ok), .rd_stall(rd_stall), .mode_o(mode_o),
    .err_o(err_o), .tries_o(tries_o), .arr_start(arr_start),
    .pg_base_o(pg_base_o), .pg_data_o(pg_data_o));

  // {restart, sel, data, mode, err}
  localparam int NV = 14;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b1, 8'h02, 3'd0, 5'h00},  // R1 erase setup
    {1'b0, 1'b0, 8'h05, 3'd2, 5'h00},  // R1 erase
    {1'b0, 1'b0, 8'h01, 3'd0, 5'h00},  // R1 back to idle
    {1'b0, 1'b1, 8'h00, 3'd0, 5'h00},  // R1 drop setup
    {1'b0, 1'b0, 8'h11, 3'd4, 5'h00},  // R1 erase-verify
    {1'b0, 1'b0, 8'h01, 3'd0, 5'h00},  // R1 idle
    {1'b0, 1'b0, 8'h09, 3'd3, 5'h00},  // R1 program-verify
    {1'b0, 1'b0, 8'h05, 3'd0, 5'h01},  // R11 switch while active
    {1'b1, 1'b0, 8'h03, 3'd0, 5'h01},  // R2 program without setup
    {1'b1, 1'b0, 8'h07, 3'd0, 5'h01},  // R11 two actions
    {1'b1, 1'b1, 8'h03, 3'd0, 5'h01},  // R11 two setups
    {1'b1, 1'b0, 8'h05, 3'd0, 5'h01},  // R2 erase without setup
    {1'b1, 1'b1, 8'h01, 3'd0, 5'h00},  // R5 program setup
    {1'b0, 1'b0, 8'h03, 3'd0, 5'h04}   // R5 program with empty page
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rw(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bw(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bw_valid = 1'b1; bw_addr = a; bw_data = d;
    @(negedge clk);
    bw_valid = 1'b0;
  endtask

  task automatic load(input logic [ADDR_W-1:0] base, input int n);
    for (int i = 0; i < n; i++) bw(base + ADDR_W'(i), 8'(i * 7 + 3));
  endtask

  task automatic restart_nowait();
    rw(1'b0, 8'h00);
    rw(1'b0, 8'h01);
  endtask

  task automatic restart();
    restart_nowait();
    idle(40);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R13 reset state
    chk("R13 mode", 32'(mode_o), 0);
    chk("R13 err", 32'(err_o), 0);
    chk("R13 tries", 32'(tries_o), 0);
    chk("R13 start", 32'(arr_start), 0);
    rd_req = 1'b1; #1;
    chk("R13 read", 32'(rd_ok), 1);
    rd_req = 1'b0;

    // table walk: R1 R2 R5 R11
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][17]) restart();
      rw(VEC[v][16], VEC[v][15:8]);
      idle(20);
      chk($sformatf("R1/R2/R11 row %0d mode", v), 32'(mode_o), 32'(VEC[v][7:5]));
      chk($sformatf("R1/R2/R11 row %0d err", v), 32'(err_o), 32'(VEC[v][4:0]));
    end

    // R5 R1 R4 full program flow
    restart();
    rw(1'b1, 8'h01);
    load(16'h0120, 32);
    rw(1'b0, 8'h03);
    chk("R1 start pulse", 32'(arr_start), 1);
    chk("R5 enter program", 32'(mode_o), 1);
    chk("R5 page base", 32'(pg_base_o), 32'h0120);
    chk("R5 page byte 31", 32'(pg_data_o[31*8 +: 8]), 220);
    chk("R9 tries one", 32'(tries_o), 1);
    idle(1);
    chk("R1 start single", 32'(arr_start), 0);
    rd_req = 1'b1; #1;
    chk("R4 stall", 32'(rd_stall), 1);
    chk("R4 no grant", 32'(rd_ok), 0);
    rw(1'b0, 8'h01);
    #1;
    chk("R4 grant idle", 32'(rd_ok), 1);
    rd_req = 1'b0;
    rw(1'b0, 8'h03);
    chk("R5 page dropped after program", 32'(err_o), 32'h04);

    // R5 short page
    restart();
    rw(1'b1, 8'h01);
    load(16'h0300, 31);
    idle(5);
    rw(1'b0, 8'h03);
    chk("R5 31 bytes", 32'(err_o), 32'h04);

    // R7 byte before enable settles
    restart_nowait();
    bw(16'h0100, 8'h55);
    chk("R7 early byte", 32'(err_o), 32'h02);

    // R8 action right after setup, then late success
    restart();
    load(16'h0140, 32);
    rw(1'b1, 8'h01);
    rw(1'b0, 8'h03);
    chk("R8 early action mode", 32'(mode_o), 0);
    chk("R8 early action err", 32'(err_o), 32'h02);
    idle(20);
    rw(1'b0, 8'h03);
    chk("R8 after wait", 32'(mode_o), 1);

    // R6 alignment and continuity
    restart();
    bw(16'h0121, 8'h01);
    chk("R6 misaligned", 32'(err_o), 32'h04);
    restart();
    bw(16'h0100, 8'h01);
    bw(16'h0102, 8'h02);
    chk("R6 gap", 32'(err_o), 32'h04);
    rw(1'b1, 8'h01);
    load(16'h0200, 32);
    rw(1'b0, 8'h03);
    chk("R6 fresh page after discard", 32'(mode_o), 1);
    chk("R6 fresh base", 32'(pg_base_o), 32'h0200);

    // R10 non-erased target
    restart();
    bw_blank = 1'b0;
    bw(16'h0100, 8'h00);
    bw_blank = 1'b1;
    chk("R10 not blank", 32'(err_o), 32'h08);

    // R3 write-enable gate
    restart();
    rw(1'b1, 8'h01);
    load(16'h0400, 32);
    fwe_i = 1'b0;
    rw(1'b0, 8'h03);
    chk("R3 gated mode", 32'(mode_o), 0);
    chk("R3 gated err", 32'(err_o), 0);
    rw(1'b1, 8'h02);
    chk("R3 gated setup err", 32'(err_o), 0);
    fwe_i = 1'b1;
    rw(1'b0, 8'h03);
    chk("R3 state kept", 32'(mode_o), 1);

    // R9 attempt limit, then R12 clear
    restart();
    rw(1'b1, 8'h01);
    idle(20);
    for (int k = 0; k < 2; k++) begin
      load(16'h0500, 32);
      rw(1'b0, 8'h03);
      rw(1'b0, 8'h01);
    end
    chk("R9 tries at max", 32'(tries_o), 2);
    load(16'h0500, 32);
    rw(1'b0, 8'h03);
    chk("R9 refused mode", 32'(mode_o), 0);
    chk("R9 limit err", 32'(err_o), 32'h10);
    rw(1'b0, 8'h00);
    chk("R12 err cleared", 32'(err_o), 0);
    chk("R12 tries cleared", 32'(tries_o), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule